// File: doc/BRIEF.md
# PLL Reset and Lock Qualification Sequencer

This controller brings a source-synchronous serializer/deserializer path into service safely. After reset or on request it holds the PLL's asynchronous reset for a minimum time given in picoseconds. It then releases the reset and watches the PLL lock indicator. The serial data paths are released only once lock has been seen high, without a break, for a programmable number of reference-clock cycles. A transfer between the fast serial domain and the slow parallel domain therefore never runs while the PLL output phases may still be wrong.

The lock indicator arrives asynchronously and passes through a two-flop synchronizer. If lock does not arrive within a programmable window, the controller drives the PLL reset again. Once running, a loss of lock removes the ready flag. In the optional relock mode, the same loss also restarts the whole PLL reset sequence. A restart request forces the reset state from any state.

Top module: `serdes_pll_seq`

## Requirements
- R1: While `rst_n` is low, `pll_reset`, `tx_data_reset` and `rx_data_reset` are 1 and `ready` is 0.
- R2: Each PLL reset pulse lasts exactly RC = ceil(MIN_RESET_PS / CLK_PERIOD_PS) cycles, with a minimum of 1, counted from the last clock edge that samples `restart_req` high. Holding `restart_req` high for H edges gives a pulse of H+RC-1 cycles.
- R3: A high `restart_req` sampled at an edge makes `pll_reset` 1 and `ready` 0 after that edge, whatever the state.
- R4: `lock_in` is synchronized by two flops. When the sequencer is waiting and `lock_in` stays high, `ready` rises after rising edge number max(`qual_len`,1)+3, counting the first edge that samples `lock_in` high as edge 1.
- R5: Any low synchronized lock sample before qualification restarts the count. A lock pulse shorter than `qual_len` cycles never raises `ready`.
- R6: A `qual_len` of 0 behaves as 1.
- R7: If no lock arrives for `timeout_len` cycles after `pll_reset` falls, `pll_reset` rises again, so it is low for exactly `timeout_len` cycles. A `timeout_len` of 0 disables the timeout.
- R8: `tx_data_reset` and `rx_data_reset` equal the inverse of `ready` on every cycle, and `ready` is never 1 while `pll_reset` is 1.
- R9: When lock drops while ready, `ready` falls after the third edge that samples `lock_in` low. With `auto_relock_en` = 0, `pll_reset` stays 0 and the sequencer waits for lock again.
- R10: With `auto_relock_en` = 1, a loss of lock while ready raises `pll_reset` on the same edge that drops `ready`, for RC cycles.
- R11: Lock samples taken while `pll_reset` is 1 do not count. If lock stays high through a reset pulse, `ready` rises after edge number max(`qual_len`,1)+1 after the edge on which `pll_reset` fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_req | input | 1 | Force the PLL reset sequence |
| lock_in | input | 1 | Asynchronous PLL lock indicator |
| auto_relock_en | input | 1 | Restart the PLL reset when lock is lost while ready |
| qual_len | input | QUAL_W | Consecutive lock cycles needed to qualify (0 means 1) |
| timeout_len | input | TMO_W | Wait-for-lock limit in cycles (0 disables) |
| pll_reset | output | 1 | PLL asynchronous reset, active high |
| tx_data_reset | output | 1 | Transmit data path reset, active high |
| rx_data_reset | output | 1 | Receive data path reset, active high |
| ready | output | 1 | Lock qualified, data paths released |

## Verification
The assertions check four things on every cycle: no PLL reset pulse ends sooner than the minimum count, `ready` rises only after the synchronized lock has been high for the qualification length, a restart request always forces reset on the next cycle, and the data resets always track `ready`. Only the bench scenarios show the exact lengths. These are the reset pulse for held restart requests under two rounding cases, the timeout window and its disable value, the qualification latency for each count, the rejection of short lock glitches, and the different reaction to lock loss with and without automatic relock.

// File: rtl/serdes_pll_seq_pkg.sv
// Package: shared state encoding for the PLL reset / lock qualify sequencer.
package serdes_pll_seq_pkg;
    typedef enum logic [1:0] {
        ST_PLL_RST   = 2'd0,
        ST_LOCK_WAIT = 2'd1,
        ST_LOCK_QUAL = 2'd2,
        ST_LINK_UP   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/serdes_seq_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the input is a slow level and not a pulse.
module serdes_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/serdes_seq_lockfilt.sv
// Lock stability filter: counts consecutive high samples of synchronized lock.
// qualified goes high once the run reaches qual_len (0 treated as 1).
// Assumes: clr is held while the PLL is in reset so those samples do not count.
module serdes_seq_lockfilt #(
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              lock_s,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              qualified
);
    localparam logic [QUAL_W-1:0] RUN_MAX = '1;

    logic [QUAL_W-1:0] run_q;
    logic [QUAL_W-1:0] need;

    // Saturating run-length counter, cleared by any low sample or by clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !lock_s) run_q <= '0;
        else if (run_q != RUN_MAX)    run_q <= run_q + 1'b1;
    end

    // Effective threshold: a zero length behaves as one cycle.
    always_comb begin
        need      = (qual_len == '0) ? QUAL_W'(1) : qual_len;
        qualified = (run_q >= need);
    end
endmodule

// File: rtl/serdes_seq_timer.sv
// Saturating up-counter shared by the reset-pulse and lock-timeout phases.
// Assumes: clr is pulsed by the controller on every state entry.
module serdes_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count cycles in the current state, restarting from zero on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        count <= '0;
        else if (count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/serdes_seq_fsm.sv
// Sequencer state machine with registered reset and ready outputs.
// Assumes: cnt is zero in the cycle after each state entry; lock_s is synchronous.
module serdes_seq_fsm
    import serdes_pll_seq_pkg::*;
#(
    parameter int RST_CYC = 2,
    parameter int TMO_W   = 16,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_req,
    input  logic             lock_s,
    input  logic             qualified,
    input  logic             auto_relock_en,
    input  logic [TMO_W-1:0] timeout_len,
    input  logic [CNT_W-1:0] cnt,
    output seq_state_e       state,
    output logic             timer_clr,
    output logic             pll_reset,
    output logic             tx_data_reset,
    output logic             rx_data_reset,
    output logic             ready
);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYC - 1);

    seq_state_e       state_n;
    logic [CNT_W-1:0] tmo_last;

    // Next-state logic; a restart request overrides every state.
    always_comb begin
        tmo_last = CNT_W'(timeout_len) - 1'b1;
        state_n  = state;
        if (restart_req) begin
            state_n = ST_PLL_RST;
        end else begin
            case (state)
                ST_PLL_RST:   if (cnt >= RST_LAST) state_n = ST_LOCK_WAIT;
                ST_LOCK_WAIT: begin
                    if (lock_s)                                          state_n = ST_LOCK_QUAL;
                    else if ((timeout_len != '0) && (cnt >= tmo_last))   state_n = ST_PLL_RST;
                end
                ST_LOCK_QUAL: begin
                    if (!lock_s)        state_n = ST_LOCK_WAIT;
                    else if (qualified) state_n = ST_LINK_UP;
                end
                ST_LINK_UP:   if (!lock_s) state_n = auto_relock_en ? ST_PLL_RST : ST_LOCK_WAIT;
                default:      state_n = ST_PLL_RST;
            endcase
        end
        timer_clr = restart_req || (state_n != state);
    end

    // State register and glitch-free registered outputs decoded from next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_PLL_RST;
            pll_reset     <= 1'b1;
            tx_data_reset <= 1'b1;
            rx_data_reset <= 1'b1;
            ready         <= 1'b0;
        end else begin
            state         <= state_n;
            pll_reset     <= (state_n == ST_PLL_RST);
            tx_data_reset <= (state_n != ST_LINK_UP);
            rx_data_reset <= (state_n != ST_LINK_UP);
            ready         <= (state_n == ST_LINK_UP);
        end
    end
endmodule

// File: rtl/serdes_pll_seq.sv
// Top: PLL reset pulse, lock synchronization, stability qualification and
// data-path reset release for a source-synchronous serial link.
// Assumes: clk is the free-running reference clock of period CLK_PERIOD_PS.
module serdes_pll_seq
    import serdes_pll_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int MIN_RESET_PS  = 10000,
    parameter int QUAL_W        = 8,
    parameter int TMO_W         = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_req,
    input  logic              lock_in,
    input  logic              auto_relock_en,
    input  logic [QUAL_W-1:0] qual_len,
    input  logic [TMO_W-1:0]  timeout_len,
    output logic              pll_reset,
    output logic              tx_data_reset,
    output logic              rx_data_reset,
    output logic              ready
);
    localparam int RST_RAW = (MIN_RESET_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RST_CYC = (RST_RAW < 1) ? 1 : RST_RAW;
    localparam int RST_W   = $clog2(RST_CYC + 1);
    localparam int CNT_W   = (RST_W > TMO_W) ? RST_W : TMO_W;

    logic             lock_sync;
    logic             lock_ok;
    logic             timer_clr;
    logic [CNT_W-1:0] cnt;
    seq_state_e       state;

    serdes_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_async(lock_in), .q_sync(lock_sync)
    );

    serdes_seq_lockfilt #(.QUAL_W(QUAL_W)) filt_i (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_PLL_RST),
        .lock_s(lock_sync), .qual_len(qual_len), .qualified(lock_ok)
    );

    serdes_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr), .count(cnt)
    );

    serdes_seq_fsm #(.RST_CYC(RST_CYC), .TMO_W(TMO_W), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .lock_s(lock_sync),
        .qualified(lock_ok), .auto_relock_en(auto_relock_en), .timeout_len(timeout_len),
        .cnt(cnt), .state(state), .timer_clr(timer_clr), .pll_reset(pll_reset),
        .tx_data_reset(tx_data_reset), .rx_data_reset(rx_data_reset), .ready(ready)
    );
endmodule

// File: rtl/serdes_pll_seq_chk.sv
// Checker bound to serdes_pll_seq: pulse length, qualification, restart, resets.
// Assumes: lock_q is the synchronized lock level inside the top.
module serdes_pll_seq_chk #(
    parameter int RST_CYC = 2,
    parameter int QUAL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart_req,
    input logic              lock_q,
    input logic [QUAL_W-1:0] qual_len,
    input logic              pll_reset,
    input logic              tx_data_reset,
    input logic              rx_data_reset,
    input logic              ready
);
    localparam int HW = $clog2(RST_CYC + 2) + 1;
    logic [HW-1:0]     hi_cnt;
    logic [QUAL_W:0]   lk_run;
    logic [QUAL_W:0]   need;

    // Length of the current PLL reset pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !pll_reset) hi_cnt <= '0;
        else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
    end

    // Independent run length of synchronized lock, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !lock_q) lk_run <= '0;
        else if (lk_run != '1) lk_run <= lk_run + 1'b1;
    end

    assign need = (qual_len == '0) ? (QUAL_W+1)'(1) : {1'b0, qual_len};

    AST_RST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_reset) |-> (hi_cnt >= HW'(RST_CYC))); // R2
    AST_RESTART_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (pll_reset && !ready)); // R3
    AST_READY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (lk_run >= need)); // R4
    AST_DATA_RST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_data_reset == !ready) && (rx_data_reset == !ready)); // R8
    AST_NO_READY_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_reset && ready)); // R8
endmodule

bind serdes_pll_seq serdes_pll_seq_chk #(.RST_CYC(RST_CYC), .QUAL_W(QUAL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .lock_q(lock_sync),
    .qual_len(qual_len), .pll_reset(pll_reset), .tx_data_reset(tx_data_reset),
    .rx_data_reset(rx_data_reset), .ready(ready)
);

// File: tb/serdes_pll_seq_tb_top.sv
// Bench: sweeps reset-hold, timeout and qualification lengths on a small configuration.
module serdes_pll_seq_tb_top;
    localparam int QW = 4;
    localparam int TW = 6;
    localparam int RC_A = 2; // ceil(10000/5000)
    localparam int RC_B = 3; // ceil(11000/5000)

    logic clk = 1'b0;
    logic rst_n, restart_req, lock_in, auto_relock_en;
    logic [QW-1:0] qual_len;
    logic [TW-1:0] timeout_len;
    logic pll_reset, tx_data_reset, rx_data_reset, ready;
    logic pll_reset_b, tx_b, rx_b, ready_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serdes_pll_seq #(.CLK_PERIOD_PS(5000), .MIN_RESET_PS(10000), .QUAL_W(QW), .TMO_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .lock_in(lock_in),
        .auto_relock_en(auto_relock_en), .qual_len(qual_len), .timeout_len(timeout_len),
        .pll_reset(pll_reset), .tx_data_reset(tx_data_reset), .rx_data_reset(rx_data_reset),
        .ready(ready)
    );

    serdes_pll_seq #(.CLK_PERIOD_PS(5000), .MIN_RESET_PS(11000), .QUAL_W(QW), .TMO_W(TW)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .lock_in(lock_in),
        .auto_relock_en(auto_relock_en), .qual_len(qual_len), .timeout_len(timeout_len),
        .pll_reset(pll_reset_b), .tx_data_reset(tx_b), .rx_data_reset(rx_b),
        .ready(ready_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Restart pulse, then wait until the PLL reset has been released.
    task automatic restart_and_release();
        restart_req = 1'b1;
        step(1);
        restart_req = 1'b0;
        for (int i = 0; i < 50 && pll_reset; i++) step(1);
    endtask

    // Raise lock and return the number of negedges until ready.
    task automatic lock_latency(output int n);
        bit track_ok = 1'b1;
        lock_in = 1'b1;
        n = 0;
        do begin
            step(1);
            n++;
            if (tx_data_reset != !ready || rx_data_reset != !ready) track_ok = 1'b0;
        end while (!ready && n < 60);
        chk(track_ok, "R8 data resets track ready", int'(track_ok), 1);
    endtask

    initial begin
        int n, c1, c2, exp_q;
        rst_n = 1'b0; restart_req = 1'b0; lock_in = 1'b0; auto_relock_en = 1'b0;
        qual_len = 4'd3; timeout_len = '0;
        step(3);
        // R1: reset state of both instances
        chk(pll_reset && pll_reset_b, "R1 pll_reset in reset", int'(pll_reset), 1);
        chk(tx_data_reset && rx_data_reset, "R1 data resets in reset", int'(tx_data_reset), 1);
        chk(!ready && !ready_b, "R1 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        step(10);

        // R2: reset pulse length for held restart, two rounding cases
        for (int h = 1; h <= 4; h++) begin
            c1 = 0; c2 = 0;
            for (int i = 0; i < h + 10; i++) begin
                restart_req = (i < h);
                step(1);
                c1 += int'(pll_reset);
                c2 += int'(pll_reset_b);
            end
            chk(c1 == h + RC_A - 1, "R2 pulse length exact period", c1, h + RC_A - 1);
            chk(c2 == h + RC_B - 1, "R2 pulse length rounded up", c2, h + RC_B - 1);
        end

        // R7: timeout sweep, 0 disables
        for (int t = 0; t <= 5; t++) begin
            timeout_len = TW'(t);
            restart_and_release();
            n = 0;
            while (!pll_reset && n < 40) begin n++; step(1); end
            chk(n == ((t == 0) ? 40 : t), "R7 lock timeout window", n, (t == 0) ? 40 : t);
        end
        timeout_len = '0;

        // R4/R6: qualification latency sweep
        for (int q = 0; q <= 6; q++) begin
            qual_len = QW'(q);
            lock_in = 1'b0;
            restart_and_release();
            step(2);
            lock_latency(n);
            exp_q = ((q == 0) ? 1 : q) + 3;
            chk(n == exp_q, (q == 0) ? "R6 zero qual length" : "R4 qualify latency", n, exp_q);
            lock_in = 1'b0;
            step(6);
        end

        // R5: glitch shorter than qual_len is rejected, then a full lock qualifies
        qual_len = 4'd4;
        restart_and_release();
        lock_in = 1'b1;
        step(3);
        lock_in = 1'b0;
        c1 = 0;
        for (int i = 0; i < 10; i++) begin step(1); c1 += int'(ready); end
        chk(c1 == 0, "R5 short lock glitch ignored", c1, 0);
        lock_latency(n);
        chk(n == 7, "R5 count restarts after glitch", n, 7);

        // R9: loss of lock without automatic relock
        lock_in = 1'b0;
        n = 0;
        do begin step(1); n++; end while (ready && n < 20);
        chk(n == 3, "R9 ready drop latency", n, 3);
        c1 = int'(pll_reset);
        for (int i = 0; i < 10; i++) begin step(1); c1 += int'(pll_reset); end
        chk(c1 == 0, "R9 no pll reset on loss", c1, 0);
        lock_latency(n);
        chk(n == 7, "R9 waits for lock again", n, 7);

        // R10: loss of lock with automatic relock
        auto_relock_en = 1'b1;
        lock_in = 1'b0;
        n = 0;
        do begin step(1); n++; end while (ready && n < 20);
        chk(n == 3 && pll_reset, "R10 relock starts with ready drop", n, 3);
        c1 = 0;
        while (pll_reset && c1 < 20) begin c1++; step(1); end
        chk(c1 == RC_A, "R10 relock pulse length", c1, RC_A);
        auto_relock_en = 1'b0;

        // R3: restart from the ready state
        lock_latency(n);
        chk(ready == 1'b1, "R3 ready before restart", int'(ready), 1);
        restart_req = 1'b1;
        step(1);
        restart_req = 1'b0;
        chk(pll_reset && !ready, "R3 restart forces reset", int'(ready), 0);

        // R11: lock high through the reset pulse does not pre-qualify
        while (pll_reset) step(1);
        n = 0;
        while (!ready && n < 30) begin step(1); n++; end
        chk(n == 5, "R11 samples in reset not counted", n, 5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule